// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block runs a single transfer on an 8-bit NAND flash bus each time it is asked. An upstream controller hands it a request made of a two-bit kind and one byte. The kinds are command, address, data write and data read. The block then places the byte on the shared I/O lines and raises the matching qualifier: the command latch for commands, the address latch for addresses, and neither for data. It frames the transfer with a write strobe or a read strobe. Three timing parameters shape every transfer: the setup before the strobe falls, the length of the strobe, and the hold after the strobe rises.

The chip-enable pin follows a separate select input and does not change from transfer to transfer. A read transfer captures the bus byte on the clock edge where the read strobe returns high, and presents that byte with a one-cycle valid pulse. The busy/ready line from the flash passes through a two-stage synchroniser and is reported as a ready flag. A busy output blocks new requests until the hold phase ends. A done pulse marks the first idle cycle. Longer operations are built upstream from a series of these transfers.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is applied and just after it: ce_n_o=1, we_n_o=1, re_n_o=1, cle_o=0, ale_o=0, io_oe_o=0, busy_o=0, done_o=0, rd_valid_o=0, ready_o=0.
- R2: The kind encoding is 0 command, 1 address, 2 data write, 3 data read. For the whole transfer, cle_o=1 only for kind 0 and ale_o=1 only for kind 1. Both are 0 for kinds 2 and 3, and the two are never 1 together.
- R3: After a request is accepted, the transfer shows exactly SETUP_CLKS busy cycles before the strobe falls. A value of 0 is legal.
- R4: The strobe stays low for exactly PULSE_CODE+1 cycles.
- R5: After the strobe rises, busy_o stays high for exactly HOLD_CLKS further cycles. A value of 0 is legal.
- R6: Kinds 0, 1 and 2 pulse we_n_o. Kind 3 pulses re_n_o. The two strobes are never low together.
- R7: io_oe_o is 1 and io_out_o carries the request byte throughout transfers of kinds 0, 1 and 2. io_oe_o is 0 during reads and while idle.
- R8: A read captures io_in_i on the edge where re_n_o rises. rd_valid_o is 1 for exactly the next cycle, with rd_byte_o holding the captured byte. rd_valid_o never pulses for the other kinds.
- R9: busy_o is 1 from the cycle after acceptance until the hold ends. done_o is 1 for exactly the first idle cycle. A request presented while busy_o is 1 has no effect.
- R10: ce_n_o equals the inverse of sel_i one clock later, whatever transfers are in progress.
- R11: ready_o equals rb_n_i delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Select the flash device |
| req_valid_i | input | 1 | Transfer request |
| req_kind_i | input | 2 | Transfer kind (0 cmd, 1 addr, 2 write, 3 read) |
| req_byte_i | input | 8 | Byte for command, address or write |
| busy_o | output | 1 | Transfer in progress, requests ignored |
| done_o | output | 1 | One-cycle pulse when a transfer finishes |
| rd_valid_o | output | 1 | Read byte valid pulse |
| rd_byte_o | output | 8 | Captured read byte |
| ready_o | output | 1 | Synchronised flash ready flag |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch qualifier |
| ale_o | output | 1 | Address latch qualifier |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| io_out_o | output | 8 | Byte driven onto the I/O bus |
| io_oe_o | output | 1 | I/O bus output enable |
| io_in_i | input | 8 | Byte sampled from the I/O bus |
| rb_n_i | input | 1 | Flash ready (1) or busy (0) |

## Verification
The assertions check on every cycle the invariants that hold whatever the stimulus:
- the two latch qualifiers are exclusive, and so are the two strobes;
- the bus is driven under a write strobe and released under a read strobe;
- the strobe length matches PULSE_CODE+1, measured with a counter;
- the byte stays stable during a transfer;
- the read valid and done pulses have the right shape.

Only the bench scenarios can show the rest, because each needs a reference built from the request:
- the exact setup and hold cycle counts, including the zero settings on a second instance;
- the byte seen by the flash model at the write strobe, and the byte returned on a read;
- that a request raised while busy is dropped;
- the select and ready latencies.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WDATA = 2'd2,
    K_RDATA = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // strobe length in clocks for a given field value
  function automatic int strobe_clks(int code);
    return code + 1;
  endfunction

  // counter bits needed to count down from n-1
  function automatic int cnt_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic logic drives_bus(kind_e k);
    return k != K_RDATA;
  endfunction

endpackage

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_cyc_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CODE = 1,
  parameter int HOLD_CLKS  = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   strobe_last,
  output logic   finish
);
  localparam int PULSE_CLKS = strobe_clks(PULSE_CODE);
  localparam int MAX_A = (SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS;
  localparam int MAXC  = (MAX_A > PULSE_CLKS) ? MAX_A : PULSE_CLKS;
  localparam int CW    = cnt_bits(MAXC);

  phase_e        phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero    = (cnt_q == '0);
  assign strobe_last = (phase == PH_STROBE) && cnt_zero;
  assign finish      = (strobe_last && (HOLD_CLKS == 0)) ||
                       ((phase == PH_HOLD) && cnt_zero);

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt_q;
    unique case (phase)
      PH_IDLE: if (start) begin
        if (SETUP_CLKS > 0) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(SETUP_CLKS - 1);
        end else begin
          phase_d = PH_STROBE;
          cnt_d   = CW'(PULSE_CLKS - 1);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = CW'(PULSE_CLKS - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          if (HOLD_CLKS > 0) begin
            phase_d = PH_HOLD;
            cnt_d   = CW'(HOLD_CLKS - 1);
          end else phase_d = PH_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      phase <= phase_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_pin_drv.sv
module nand_pin_drv
  import nand_cyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel,
  input  phase_e phase,
  input  kind_e  kind,
  output logic   ce_n,
  output logic   cle,
  output logic   ale,
  output logic   we_n,
  output logic   re_n,
  output logic   oe
);
  logic active, strobing;

  assign active   = (phase != PH_IDLE);
  assign strobing = (phase == PH_STROBE);
  assign cle      = active && (kind == K_CMD);
  assign ale      = active && (kind == K_ADDR);
  assign oe       = active && drives_bus(kind);
  assign we_n     = !(strobing && drives_bus(kind));
  assign re_n     = !(strobing && !drives_bus(kind));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_n <= 1'b1;
    else        ce_n <= !sel;
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nand_cyc_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CODE = 1,
  parameter int HOLD_CLKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  input  logic [7:0] req_byte_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_byte_o,
  output logic       ready_o,
  output logic       ce_n_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic [7:0] io_out_o,
  output logic       io_oe_o,
  input  logic [7:0] io_in_i,
  input  logic       rb_n_i
);
  phase_e     phase;
  kind_e      kind_q;
  logic [7:0] byte_q;
  logic       accept, strobe_last, finish;

  assign busy_o   = (phase != PH_IDLE);
  assign accept   = req_valid_i && !busy_o;
  assign io_out_o = byte_q;

  nand_phase_seq #(
    .SETUP_CLKS(SETUP_CLKS), .PULSE_CODE(PULSE_CODE), .HOLD_CLKS(HOLD_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .phase(phase), .strobe_last(strobe_last), .finish(finish)
  );

  nand_pin_drv u_pins (
    .clk(clk), .rst_n(rst_n), .sel(sel_i), .phase(phase), .kind(kind_q),
    .ce_n(ce_n_o), .cle(cle_o), .ale(ale_o), .we_n(we_n_o), .re_n(re_n_o),
    .oe(io_oe_o)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk(clk), .rst_n(rst_n), .async_in(rb_n_i), .sync_out(ready_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q     <= K_CMD;
      byte_q     <= '0;
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_byte_o  <= '0;
    end else begin
      if (accept) begin
        kind_q <= kind_e'(req_kind_i);
        byte_q <= req_byte_i;
      end
      done_o     <= finish;
      rd_valid_o <= strobe_last && (kind_q == K_RDATA);
      if (strobe_last && (kind_q == K_RDATA)) rd_byte_o <= io_in_i;
    end
  end
endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
  parameter int PULSE_CODE = 1,
  parameter int HOLD_CLKS  = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       io_oe,
  input logic [7:0] io_out,
  input logic       rd_valid,
  input logic       strobe_last
);
  logic stb_low, stb_low_q;
  int   low_len;

  assign stb_low = !we_n || !re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_low_q <= 1'b0;
      low_len   <= 0;
    end else begin
      stb_low_q <= stb_low;
      low_len   <= stb_low ? low_len + 1 : 0;
    end
  end

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  assert_we_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> io_oe);
  assert_re_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low_q && !stb_low) |-> (low_len == PULSE_CODE + 1));
  assert_last_is_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |-> stb_low);
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low_q && !stb_low && (HOLD_CLKS > 0)) |-> busy);
  assert_rdv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid || $past(strobe_last));
  assert_rdv_after_re_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (re_n && $past(!re_n)));
  assert_byte_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(io_out));
  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(
  .PULSE_CODE(PULSE_CODE), .HOLD_CLKS(HOLD_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .cle(cle_o),
  .ale(ale_o), .we_n(we_n_o), .re_n(re_n_o), .io_oe(io_oe_o),
  .io_out(io_out_o), .rd_valid(rd_valid_o), .strobe_last(strobe_last)
);

// File: tb/tb_nand_cycle_gen.sv
module tb_nand_cycle_gen;
  localparam int S_A = 2, P_A = 1, H_A = 3;
  localparam int S_B = 0, P_B = 0, H_B = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic       sel_w      [2];
  logic       req_w      [2];
  logic [1:0] kind_w     [2];
  logic [7:0] byte_w     [2];
  logic [7:0] flash_rd   [2];
  logic [7:0] io_in_w    [2];
  logic       rb_w       [2];
  logic       busy_w     [2];
  logic       done_w     [2];
  logic       rdv_w      [2];
  logic [7:0] rdb_w      [2];
  logic       rdy_w      [2];
  logic       ce_w       [2];
  logic       cle_w      [2];
  logic       ale_w      [2];
  logic       we_w       [2];
  logic       re_w       [2];
  logic [7:0] out_w      [2];
  logic       oe_w       [2];

  // flash model drives the bus only under the read strobe
  assign io_in_w[0] = !re_w[0] ? flash_rd[0] : 8'h00;
  assign io_in_w[1] = !re_w[1] ? flash_rd[1] : 8'h00;

  nand_cycle_gen #(.SETUP_CLKS(S_A), .PULSE_CODE(P_A), .HOLD_CLKS(H_A)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_w[0]), .req_valid_i(req_w[0]),
    .req_kind_i(kind_w[0]), .req_byte_i(byte_w[0]), .busy_o(busy_w[0]),
    .done_o(done_w[0]), .rd_valid_o(rdv_w[0]), .rd_byte_o(rdb_w[0]),
    .ready_o(rdy_w[0]), .ce_n_o(ce_w[0]), .cle_o(cle_w[0]), .ale_o(ale_w[0]),
    .we_n_o(we_w[0]), .re_n_o(re_w[0]), .io_out_o(out_w[0]), .io_oe_o(oe_w[0]),
    .io_in_i(io_in_w[0]), .rb_n_i(rb_w[0]));

  nand_cycle_gen #(.SETUP_CLKS(S_B), .PULSE_CODE(P_B), .HOLD_CLKS(H_B)) dut_zero (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_w[1]), .req_valid_i(req_w[1]),
    .req_kind_i(kind_w[1]), .req_byte_i(byte_w[1]), .busy_o(busy_w[1]),
    .done_o(done_w[1]), .rd_valid_o(rdv_w[1]), .rd_byte_o(rdb_w[1]),
    .ready_o(rdy_w[1]), .ce_n_o(ce_w[1]), .cle_o(cle_w[1]), .ale_o(ale_w[1]),
    .we_n_o(we_w[1]), .re_n_o(re_w[1]), .io_out_o(out_w[1]), .io_oe_o(oe_w[1]),
    .io_in_i(io_in_w[1]), .rb_n_i(rb_w[1]));

  function automatic int exp_setup(int u); return (u == 0) ? S_A : S_B; endfunction
  function automatic int exp_pulse(int u); return ((u == 0) ? P_A : P_B) + 1; endfunction
  function automatic int exp_hold(int u);  return (u == 0) ? H_A : H_B; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one full transfer on instance u, measured from the pins
  task automatic run_xfer(int u, logic [1:0] k, logic [7:0] b, bit poke);
    int  s = 0, p = 0, h = 0, stage = 0, n = 0, guard = 0;
    bit  bad_latch = 0, bad_stb = 0, bad_bus = 0, bad_rdv = 0, bad_done = 0;
    bit  rdv_seen = 0, rdv_ok = 0;
    logic [7:0] seen = 8'h00;
    bit  is_rd = (k == 2'd3);
    flash_rd[u] = 8'($urandom);
    req_w[u] = 1'b1; kind_w[u] = k; byte_w[u] = b;
    @(negedge clk);
    req_w[u] = 1'b0;
    while (busy_w[u] && guard < 200) begin
      guard++;
      if (req_w[u]) req_w[u] = 1'b0;
      if (cle_w[u] !== (k == 2'd0) || ale_w[u] !== (k == 2'd1)) bad_latch = 1;
      if ((is_rd && !we_w[u]) || (!is_rd && !re_w[u])) bad_stb = 1;
      if (oe_w[u] !== !is_rd || (!is_rd && out_w[u] !== b)) bad_bus = 1;
      if (done_w[u]) bad_done = 1;
      if ((is_rd ? !re_w[u] : !we_w[u])) begin
        if (stage == 2) bad_stb = 1;
        stage = 1; p++;
        if (!is_rd) seen = out_w[u];
        if (rdv_w[u]) bad_rdv = 1;
      end else if (stage == 0) begin
        s++;
        if (rdv_w[u]) bad_rdv = 1;
      end else begin
        if (stage == 1) begin
          rdv_seen = 1;
          rdv_ok = (rdv_w[u] === is_rd) && (!is_rd || rdb_w[u] === flash_rd[u]);
        end else if (rdv_w[u]) bad_rdv = 1;
        stage = 2; h++;
      end
      n++;
      if (poke && n == 2) begin
        req_w[u] = 1'b1; kind_w[u] = ~k; byte_w[u] = ~b;
      end
      @(negedge clk);
    end
    req_w[u] = 1'b0;
    if (stage == 1) begin
      rdv_seen = 1;
      rdv_ok = (rdv_w[u] === is_rd) && (!is_rd || rdb_w[u] === flash_rd[u]);
    end
    chk(s == exp_setup(u), "R3", "setup cycles", s, exp_setup(u));
    chk(p == exp_pulse(u), "R4", "strobe cycles", p, exp_pulse(u));
    chk(h == exp_hold(u),  "R5", "hold cycles", h, exp_hold(u));
    chk(!bad_latch, "R2", "latch qualifiers", {cle_w[u], ale_w[u]}, k);
    chk(!bad_stb, "R6", "strobe choice", {we_w[u], re_w[u]}, k);
    chk(!bad_bus && (is_rd || seen == b), "R7", "bus byte/enable", seen, b);
    chk(rdv_seen && rdv_ok && !bad_rdv, "R8", "read capture", rdb_w[u], flash_rd[u]);
    chk(!bad_done && done_w[u] === 1'b1, "R9", "done on first idle", done_w[u], 1);
    @(negedge clk);
    chk(done_w[u] === 1'b0 && busy_w[u] === 1'b0, "R9",
        "single done, busy request dropped", {done_w[u], busy_w[u]}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int u = 0; u < 2; u++) begin
      sel_w[u] = 1'b0; req_w[u] = 1'b0; kind_w[u] = 2'd0; byte_w[u] = 8'h00;
      flash_rd[u] = 8'h00; rb_w[u] = 1'b1;
    end
    repeat (2) @(negedge clk);
    // R1 reset values, checked while reset is still held
    for (int u = 0; u < 2; u++)
      chk(ce_w[u] === 1 && we_w[u] === 1 && re_w[u] === 1 && cle_w[u] === 0 &&
          ale_w[u] === 0 && oe_w[u] === 0 && busy_w[u] === 0 && done_w[u] === 0 &&
          rdv_w[u] === 0 && rdy_w[u] === 0, "R1", "reset state",
          {ce_w[u], we_w[u], re_w[u], cle_w[u], ale_w[u], oe_w[u], busy_w[u], rdy_w[u]},
          8'b1110_0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 select to CE latency
    sel_w[0] = 1'b1;
    @(negedge clk);
    chk(ce_w[0] === 1'b0, "R10", "ce after select", ce_w[0], 0);
    sel_w[1] = 1'b1;
    @(negedge clk);
    chk(ce_w[1] === 1'b0, "R10", "ce second unit", ce_w[1], 0);

    // R11 ready synchroniser latency
    rb_w[0] = 1'b0;
    @(negedge clk);
    chk(rdy_w[0] === 1'b1, "R11", "ready after one edge", rdy_w[0], 1);
    @(negedge clk);
    chk(rdy_w[0] === 1'b0, "R11", "ready after two edges", rdy_w[0], 0);
    rb_w[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy_w[0] === 1'b1, "R11", "ready recovers", rdy_w[0], 1);

    // directed: each kind on both timing settings, busy poke on the first
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++) run_xfer(u, 2'(k), 8'hA5 ^ 8'(k), 1'b1);
    run_xfer(0, 2'd3, 8'h00, 1'b0);
    run_xfer(1, 2'd2, 8'hFF, 1'b0);

    // constrained random traffic
    for (int i = 0; i < 80; i++)
      run_xfer(i % 2, 2'($urandom), 8'($urandom), 1'($urandom));

    // R10 CE holds across a transfer
    run_xfer(0, 2'd0, 8'h90, 1'b0);
    chk(ce_w[0] === 1'b0, "R10", "ce held over transfer", ce_w[0], 0);
    sel_w[0] = 1'b0;
    @(negedge clk);
    chk(ce_w[0] === 1'b1, "R10", "ce after deselect", ce_w[0], 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule